// File: doc/BRIEF.md
# Beat-Frequency Oscillator Random Bit Source

This block turns the slow phase drift between two nearly equal free-running oscillators into a stream of random bits. Oscillator A is registered on the edges of oscillator B through a short flop chain, and the last flop acts as a phase detector. Because the two periods differ slightly, the registered value stays constant for a stretch of B cycles and then flips. A round starts at one flip of the detector and ends at the next. During the round, a counter in the B domain counts B cycles. Edge-to-edge jitter makes the length of that stretch vary by a cycle or so from round to round, and the parity of the count is the random bit.

A separate, slower sampling clock takes each finished count through a four-phase level handshake. The counter holds its value until the sampling side has captured it and released it, so the captured value is never an unfinished or freshly cleared count. Each capture then crosses into the system clock domain through a toggle synchronizer. There it appears as a one-cycle valid pulse, together with the count and its least significant bit. In simulation, both oscillators and the sampling clock are plain clock inputs.

Top module: `beat_trng`

## Requirements
- R1: A round begins when the registered copy of osc_a changes value on an osc_b edge and ends at its next change. The published count equals the number of osc_b edges strictly between those two changes.
- R2: A round whose count is zero is discarded. The block re-arms without publishing it, so a published count is never zero.
- R3: The counter saturates at 2^CNT_W-1 and does not wrap when the detector does not flip back within that range.
- R4: A finished count is held, and no new round starts, until the sampling domain has captured it and withdrawn its clear request. A sampling clock slower than a half beat therefore still publishes full-length counts.
- R5: When rnd_valid is high, rnd_bit equals bit 0 of rnd_count.
- R6: rnd_valid is high for exactly one sys_clk cycle per captured round and never in two consecutive cycles.
- R7: While rst_n is low, rnd_valid, rnd_bit and rnd_count are all zero.
- R8: When half a beat spans a non-integer number of osc_b cycles, between a quarter and three quarters of the emitted bits are ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| osc_a | input | 1 | Oscillator A, used only as data sampled by osc_b |
| osc_b | input | 1 | Oscillator B, clock of the phase detector and the counter |
| smp_clk | input | 1 | Sampling clock that captures finished counts |
| sys_clk | input | 1 | System clock of the output stream |
| rnd_valid | output | 1 | One-cycle pulse marking a new random bit |
| rnd_bit | output | 1 | Random bit, the parity of the captured count |
| rnd_count | output | CNT_W | Captured count of the round |

## Verification
The main pair is run with periods of 10.000 ns and 10.233 ns and bounded per-edge jitter. Half a beat then covers about 21.5 osc_b cycles, so every count must fall inside a narrow window computed from the period ratio, and the bit balance shows whether the parity really varies. The same pair is run again with a sampling clock much slower than a half beat. Counts that stay in the same window show that a finished count is held and not overwritten or cut short. A second instance with a 6-bit counter gets a pair whose half beat is about 100 cycles and no jitter, so every published count must sit at the saturation value of 63.

// File: rtl/trng_pkg.sv
`timescale 1ns/1ps
package trng_pkg;
  typedef enum logic [1:0] {
    BT_ARM     = 2'd0,
    BT_COUNT   = 2'd1,
    BT_DONE    = 2'd2,
    BT_RELEASE = 2'd3
  } beat_st_e;
endpackage

// File: rtl/trng_rst_sync.sv
`timescale 1ns/1ps
module trng_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stg1;
  logic stg2;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg1 <= 1'b0;
      stg2 <= 1'b0;
    end else begin
      stg1 <= 1'b1;
      stg2 <= stg1;
    end
  end

  assign srst_n = stg2;
endmodule

// File: rtl/trng_sync2.sv
`timescale 1ns/1ps
module trng_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      held <= '0;
    end else begin
      meta <= d;
      held <= meta;
    end
  end

  assign q = held;
endmodule

// File: rtl/trng_beat_counter.sv
`timescale 1ns/1ps
module trng_beat_counter
  import trng_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_b,
  input  logic             rst_n,
  input  logic             osc_a,
  input  logic             clr_req,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             a_s1;
  logic             a_ph;
  logic             a_ph_q;
  logic             tgl;
  logic             clr_s;
  beat_st_e         st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             cnt_en;

  trng_sync2 #(.W(1)) u_clr_sync (
    .clk  (clk_b),
    .rst_n(rst_n),
    .d    (clr_req),
    .q    (clr_s)
  );

  // phase detector: osc_a registered on osc_b
  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      a_s1   <= 1'b0;
      a_ph   <= 1'b0;
      a_ph_q <= 1'b0;
    end else begin
      a_s1   <= osc_a;
      a_ph   <= a_s1;
      a_ph_q <= a_ph;
    end
  end

  assign tgl = a_ph ^ a_ph_q;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    cnt_en = 1'b0;
    case (st)
      BT_ARM: begin
        if (tgl) begin
          st_n   = BT_COUNT;
          cnt_n  = '0;
          cnt_en = 1'b1;
        end
      end
      BT_COUNT: begin
        if (tgl) begin
          if (cnt != '0) st_n = BT_DONE;
          else           st_n = BT_ARM;
        end else if (cnt != CNT_MAX) begin
          cnt_n  = cnt + 1'b1;
          cnt_en = 1'b1;
        end
      end
      BT_DONE: begin
        if (clr_s) begin
          st_n   = BT_RELEASE;
          cnt_n  = '0;
          cnt_en = 1'b1;
        end
      end
      BT_RELEASE: begin
        if (!clr_s) st_n = BT_ARM;
      end
      default: st_n = BT_ARM;
    endcase
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      st  <= BT_ARM;
      cnt <= '0;
    end else begin
      st <= st_n;
      if (cnt_en) cnt <= cnt_n;
    end
  end

  assign done  = (st == BT_DONE);
  assign count = cnt;

  AST_DONE_NONZERO: assert property (@(posedge clk_b) disable iff (!rst_n)
    (st == BT_DONE) |-> (cnt != '0));  // R2
  AST_SAT_HOLD: assert property (@(posedge clk_b) disable iff (!rst_n)
    (st == BT_COUNT && cnt == CNT_MAX && !tgl) |=> (cnt == CNT_MAX));  // R3
  AST_HOLD_UNTIL_CLR: assert property (@(posedge clk_b) disable iff (!rst_n)
    (st == BT_DONE && !clr_s) |=> (st == BT_DONE && $stable(cnt)));  // R4
  AST_NO_EARLY_REARM: assert property (@(posedge clk_b) disable iff (!rst_n)
    (st == BT_RELEASE && clr_s) |=> (st == BT_RELEASE));  // R4
endmodule

// File: rtl/trng_sampler.sv
`timescale 1ns/1ps
module trng_sampler #(
  parameter int CNT_W = 16
) (
  input  logic             clk_s,
  input  logic             rst_n,
  input  logic             done_async,
  input  logic [CNT_W-1:0] cnt_async,
  output logic             clr,
  output logic             tog,
  output logic [CNT_W-1:0] cap
);
  logic             done_s;
  logic             clr_q, clr_n;
  logic             tog_q;
  logic [CNT_W-1:0] cap_q;
  logic             cap_en;

  trng_sync2 #(.W(1)) u_done_sync (
    .clk  (clk_s),
    .rst_n(rst_n),
    .d    (done_async),
    .q    (done_s)
  );

  always_comb begin
    cap_en = done_s & ~clr_q;
    clr_n  = clr_q;
    if (cap_en)               clr_n = 1'b1;
    else if (clr_q && !done_s) clr_n = 1'b0;
  end

  always_ff @(posedge clk_s or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b0;
      tog_q <= 1'b0;
      cap_q <= '0;
    end else begin
      clr_q <= clr_n;
      if (cap_en) begin
        tog_q <= ~tog_q;
        cap_q <= cnt_async;
      end
    end
  end

  assign clr = clr_q;
  assign tog = tog_q;
  assign cap = cap_q;

  AST_CAPTURE_AFTER_DONE: assert property (@(posedge clk_s) disable iff (!rst_n)
    $rose(clr_q) |-> $past(done_s));  // R4
endmodule

// File: rtl/trng_sys_out.sv
`timescale 1ns/1ps
module trng_sys_out #(
  parameter int CNT_W = 16
) (
  input  logic             clk_sys,
  input  logic             rst_n,
  input  logic             tog_async,
  input  logic [CNT_W-1:0] cap_async,
  output logic             valid,
  output logic             rbit,
  output logic [CNT_W-1:0] count
);
  logic             tog_s;
  logic             tog_q;
  logic             edge_seen;
  logic             valid_q;
  logic             rbit_q;
  logic [CNT_W-1:0] count_q;

  trng_sync2 #(.W(1)) u_tog_sync (
    .clk  (clk_sys),
    .rst_n(rst_n),
    .d    (tog_async),
    .q    (tog_s)
  );

  assign edge_seen = tog_s ^ tog_q;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      valid_q <= 1'b0;
      rbit_q  <= 1'b0;
      count_q <= '0;
    end else begin
      tog_q   <= tog_s;
      valid_q <= edge_seen;
      if (edge_seen) begin
        rbit_q  <= cap_async[0];
        count_q <= cap_async;
      end
    end
  end

  assign valid = valid_q;
  assign rbit  = rbit_q;
  assign count = count_q;

  AST_VALID_PULSE: assert property (@(posedge clk_sys) disable iff (!rst_n)
    valid_q |=> !valid_q);  // R6
endmodule

// File: rtl/beat_trng.sv
`timescale 1ns/1ps
module beat_trng #(
  parameter int CNT_W = 16
) (
  input  logic             rst_n,
  input  logic             osc_a,
  input  logic             osc_b,
  input  logic             smp_clk,
  input  logic             sys_clk,
  output logic             rnd_valid,
  output logic             rnd_bit,
  output logic [CNT_W-1:0] rnd_count
);
  logic             rst_b_n;
  logic             rst_s_n;
  logic             rst_y_n;
  logic             done_b;
  logic [CNT_W-1:0] cnt_b;
  logic             clr_s;
  logic             tog_s;
  logic [CNT_W-1:0] cap_s;

  trng_rst_sync u_rst_b (.clk(osc_b),   .arst_n(rst_n), .srst_n(rst_b_n));
  trng_rst_sync u_rst_s (.clk(smp_clk), .arst_n(rst_n), .srst_n(rst_s_n));
  trng_rst_sync u_rst_y (.clk(sys_clk), .arst_n(rst_n), .srst_n(rst_y_n));

  trng_beat_counter #(.CNT_W(CNT_W)) u_beat (
    .clk_b  (osc_b),
    .rst_n  (rst_b_n),
    .osc_a  (osc_a),
    .clr_req(clr_s),
    .done   (done_b),
    .count  (cnt_b)
  );

  trng_sampler #(.CNT_W(CNT_W)) u_smp (
    .clk_s     (smp_clk),
    .rst_n     (rst_s_n),
    .done_async(done_b),
    .cnt_async (cnt_b),
    .clr       (clr_s),
    .tog       (tog_s),
    .cap       (cap_s)
  );

  trng_sys_out #(.CNT_W(CNT_W)) u_out (
    .clk_sys  (sys_clk),
    .rst_n    (rst_y_n),
    .tog_async(tog_s),
    .cap_async(cap_s),
    .valid    (rnd_valid),
    .rbit     (rnd_bit),
    .count    (rnd_count)
  );
endmodule

// File: tb/tb_beat_trng.sv
`timescale 1ps/1ps
module tb_beat_trng;
  localparam int HALF_A   = 5000;             // osc_a half period, ps
  localparam int SLIP     = 233;              // osc_b period minus osc_a period, ps
  localparam int JIT      = 40;               // per-edge jitter bound, ps
  localparam int RUN_LEN  = HALF_A / SLIP;    // samples per half beat, floor
  localparam int CNT_LO   = RUN_LEN - 2;
  localparam int CNT_HI   = RUN_LEN + 1;
  localparam int SAT_W    = 6;
  localparam int SAT_MAX  = (1 << SAT_W) - 1;
  localparam int N_FAST   = 40;
  localparam int N_TOTAL  = 52;
  localparam int N_SAT    = 6;

  logic             rst_n;
  logic             osc_a, osc_b, osc_a2, osc_b2;
  logic             smp_clk, sys_clk;
  logic             rnd_valid, rnd_bit;
  logic [15:0]      rnd_count;
  logic             sat_valid, sat_bit;
  logic [SAT_W-1:0] sat_count;

  int total, bad;
  int nmain, nsat, ones;
  int smp_half;
  bit run, slow_phase, finished;
  bit prev_v;

  beat_trng #(.CNT_W(16)) dut (
    .rst_n(rst_n), .osc_a(osc_a), .osc_b(osc_b), .smp_clk(smp_clk),
    .sys_clk(sys_clk), .rnd_valid(rnd_valid), .rnd_bit(rnd_bit),
    .rnd_count(rnd_count)
  );

  beat_trng #(.CNT_W(SAT_W)) dut_sat (
    .rst_n(rst_n), .osc_a(osc_a2), .osc_b(osc_b2), .smp_clk(smp_clk),
    .sys_clk(sys_clk), .rnd_valid(sat_valid), .rnd_bit(sat_bit),
    .rnd_count(sat_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    sys_clk = 1'b0;
    forever #5000 sys_clk = ~sys_clk;
  end

  initial begin
    smp_clk  = 1'b0;
    smp_half = 18500;
    forever #(smp_half) smp_clk = ~smp_clk;
  end

  initial begin
    int jo;
    jo = 0;
    osc_a = 1'b0;
    forever begin
      int jn;
      jn = int'($urandom_range(2 * JIT)) - JIT;
      #(HALF_A + jn - jo) osc_a = ~osc_a;
      jo = jn;
    end
  end

  initial begin
    int jo;
    bit ph;
    jo = 0;
    ph = 1'b0;
    osc_b = 1'b0;
    #700;
    forever begin
      int jn;
      jn = int'($urandom_range(2 * JIT)) - JIT;
      #(HALF_A + (SLIP / 2) + int'(ph) + jn - jo) osc_b = ~osc_b;
      jo = jn;
      ph = ~ph;
    end
  end

  initial begin
    osc_a2 = 1'b0;
    forever #(HALF_A) osc_a2 = ~osc_a2;
  end

  initial begin
    osc_b2 = 1'b0;
    #1;
    forever #(HALF_A + 25) osc_b2 = ~osc_b2;
  end

  always @(negedge sys_clk) begin
    if (run) begin
      if (prev_v && rnd_valid)
        check(1'b0, "R6 valid high two cycles", 1, 0);
      prev_v = rnd_valid;
      if (rnd_valid) begin
        nmain++;
        ones += int'(rnd_bit);
        check(rnd_count != 0, "R2 count nonzero", int'(rnd_count), 1);
        if (slow_phase)
          check(int'(rnd_count) >= CNT_LO && int'(rnd_count) <= CNT_HI,
                "R4 count window with slow sampling", int'(rnd_count), CNT_LO);
        else
          check(int'(rnd_count) >= CNT_LO && int'(rnd_count) <= CNT_HI,
                "R1 count window", int'(rnd_count), CNT_LO);
        check(rnd_bit == rnd_count[0], "R5 bit is count parity",
              int'(rnd_bit), int'(rnd_count[0]));
      end
      if (sat_valid) begin
        nsat++;
        check(int'(sat_count) == SAT_MAX, "R3 saturated count", int'(sat_count), SAT_MAX);
        check(sat_bit == 1'b1, "R5 saturated parity", int'(sat_bit), 1);
      end
    end
  end

  initial begin
    total = 0; bad = 0; nmain = 0; nsat = 0; ones = 0;
    run = 1'b0; slow_phase = 1'b0; finished = 1'b0; prev_v = 1'b0;
    rst_n = 1'b0;
    repeat (30) @(negedge sys_clk);
    check(rnd_valid == 1'b0, "R7 valid in reset", int'(rnd_valid), 0);
    check(rnd_count == '0, "R7 count in reset", int'(rnd_count), 0);
    check(rnd_bit == 1'b0, "R7 bit in reset", int'(rnd_bit), 0);
    check(sat_valid == 1'b0 && sat_count == '0, "R7 sat outputs in reset",
          int'(sat_count), 0);
    @(posedge sys_clk);
    rst_n = 1'b1;
    run = 1'b1;
    wait (nmain >= N_FAST);
    smp_half = 255500;
    @(negedge sys_clk);
    slow_phase = 1'b1;
    wait (nmain >= N_TOTAL && nsat >= N_SAT);
    @(negedge sys_clk);
    run = 1'b0;
    check(ones * 4 >= nmain && ones * 4 <= 3 * nmain, "R8 ones balance", ones, nmain / 2);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge sys_clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog expired", nmain, N_TOTAL);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule